// File: doc/BRIEF.md
# Per-Line Outstanding Request Tracker

This block sits between one processor port and its cache controller and keeps track of every memory request that has been sent downstream but not yet answered. Each incoming request carries a kind, a byte address, a byte length and an access mode. In the same cycle the block decides whether to take the request. When it accepts, it returns a fresh ID, records the request's cache line in one of two small fully associative tables (one for write-class kinds, one for read-class kinds), and on the next cycle issues a folded downstream command with the line address, a privilege bit and a cache latency. When it rejects, it returns the code -1.

A completion names a line and a class. It retires the matching entry from that class's table, which frees the line for new requests. Only one request per cache line may be in flight, counted across both tables. While anything is pending, a watchdog examines the tables once every threshold period and raises a sticky deadlock flag if any entry has been waiting at least that long. A consistency output reports any disagreement between the running outstanding count and the number of valid table entries.

Top module: `lineReqTracker`

## Requirements
- R1: Request kinds use the encoding load=0, fetch=1, store=2, rmw-read=3, rmw-write=4, locked-read=5, locked-write=6. Kinds 2 to 6 occupy the write-class table and kinds 0 and 1 occupy the read-class table. A completion retires an entry only from the table selected by `cplWrite` (1 = write class). A completion of the wrong class leaves the entry in place.
- R2: A request is rejected while the outstanding count equals MAX_OUT, or while its class table is full.
- R3: A request is rejected while its line address (byte address with the low log2(LINE_BYTES) bits cleared) is held in either table, whatever its kind or offset. A request to a neighbouring line is unaffected.
- R4: A request is rejected, and changes no state, if its offset within the line plus its length exceeds LINE_BYTES, if its kind is 7, or if its mode is 3. Offset plus length equal to LINE_BYTES is legal.
- R5: `reqAccept` and `respId` answer combinationally in the request cycle. Accepted requests receive IDs 0, 1, 2, ... counting from reset. A rejected request gets all ones (-1) and consumes no ID.
- R6: A completion retires the matching entry, lowers the outstanding count by one, and makes the line available again.
- R7: `issueCmd` follows the kind: fetch gives 0, load gives 1, store, locked-read and locked-write give 2, and both rmw kinds give 3.
- R8: Mode encoding is user=0, supervisor=1, device=2. `issueSuper` is 1 only for supervisor; device mode is issued as user.
- R9: `issueDelay` equals ICACHE_LAT for fetches and DCACHE_LAT for every other kind.
- R10: `issueValid` is high for exactly the one cycle after each accepted request, and never otherwise. It carries the line address of that request.
- R11: `deadlock` is low after reset. A watchdog check runs every THRESH cycles from the first accept made while the watchdog is idle. If any entry has been waiting at least THRESH cycles at a check, `deadlock` rises and stays high until reset.
- R12: Entries retired before reaching THRESH cycles of age never raise `deadlock`. The checks stop once a check finds the tables empty.
- R13: `countMismatch` stays low; the outstanding count always equals the number of valid entries in both tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | New request present this cycle |
| reqType | input | 3 | Request kind |
| reqAddr | input | ADDR_W | Byte address |
| reqLen | input | LEN_W | Byte length |
| reqMode | input | 2 | Access mode |
| reqAccept | output | 1 | Request taken this cycle |
| respId | output | ID_W | Assigned ID, or all ones on reject |
| cplValid | input | 1 | Completion present this cycle |
| cplWrite | input | 1 | Completion class, 1 = write class |
| cplAddr | input | ADDR_W | Line address being completed |
| issueValid | output | 1 | Downstream command valid |
| issueCmd | output | 2 | Folded downstream command |
| issueSuper | output | 1 | Supervisor privilege |
| issueLine | output | ADDR_W | Line address of the command |
| issueDelay | output | LAT_W | Cache latency to apply |
| deadlock | output | 1 | Sticky watchdog flag |
| countMismatch | output | 1 | Count and table occupancy disagree |

## Verification
The bench aims at the line-collision rule across tables. It sends a load to a line held by a store at a different offset, and a design that keyed on the full address or searched only the same-class table would accept it. It sends a completion of the wrong class and then re-requests the line, which exposes a design that retires from the wrong table. It probes the length boundary at exactly LINE_BYTES and one past it, where an off-by-one either rejects a legal access or lets an illegal one through. For the watchdog, an entry arrives late in a check period and is held past the threshold. A design that measured time since the check was armed, rather than since the entry was issued, would flag it at the first check instead of the second.

// File: rtl/lrt_pkg.sv
`timescale 1ns/1ps
package lrt_pkg;

  typedef enum logic [2:0] {
    K_LOAD    = 3'd0,
    K_FETCH   = 3'd1,
    K_STORE   = 3'd2,
    K_RMW_RD  = 3'd3,
    K_RMW_WR  = 3'd4,
    K_LOCK_RD = 3'd5,
    K_LOCK_WR = 3'd6,
    K_BAD     = 3'd7
  } reqKind_e;

  typedef enum logic [1:0] {
    C_FETCH  = 2'd0,
    C_LOAD   = 2'd1,
    C_STORE  = 2'd2,
    C_ATOMIC = 2'd3
  } dnCmd_e;

  typedef enum logic [1:0] {
    M_USER   = 2'd0,
    M_SUPER  = 2'd1,
    M_DEVICE = 2'd2,
    M_RSVD   = 2'd3
  } accMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic insWr;
    logic insRd;
    logic retWr;
    logic retRd;
  } tblStrobe_t;

  function automatic logic isWriteKind(logic [2:0] k);
    return (k == K_STORE) || (k == K_RMW_RD) || (k == K_RMW_WR) ||
           (k == K_LOCK_RD) || (k == K_LOCK_WR);
  endfunction

  function automatic logic [1:0] mapCmd(logic [2:0] k);
    case (k)
      K_FETCH:                      return C_FETCH;
      K_LOAD:                       return C_LOAD;
      K_STORE, K_LOCK_RD, K_LOCK_WR: return C_STORE;
      default:                      return C_ATOMIC;
    endcase
  endfunction

endpackage

// File: rtl/lrt_table.sv
`timescale 1ns/1ps
module lrt_table #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 26,
  parameter int TS_W   = 11,
  parameter int THRESH = 500
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [TAG_W-1:0]              lookTag,
  input  logic                          insert,
  input  logic                          retire,
  input  logic [TAG_W-1:0]              retTag,
  input  logic [TS_W-1:0]               nowTs,
  output logic                          busy,
  output logic                          full,
  output logic                          retHit,
  output logic                          stale,
  output logic [$clog2(DEPTH+1)-1:0]    validCnt
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [TS_W-1:0] THR = TS_W'(THRESH);

  logic [DEPTH-1:0] vld;
  logic [TAG_W-1:0] tag [DEPTH];
  logic [TS_W-1:0]  ts  [DEPTH];

  logic [DEPTH-1:0] lookHit, retMatch, oldEnt;
  logic             freeFound;
  logic [IDX_W-1:0] freeIdx;
  logic [CNT_W-1:0] cnt;

  // parallel tag compare and age test per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign lookHit[i]  = vld[i] && (tag[i] == lookTag);
    assign retMatch[i] = vld[i] && (tag[i] == retTag);
    assign oldEnt[i]   = vld[i] && ((nowTs - ts[i]) >= THR);
  end

  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    cnt       = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld[i] && !freeFound) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
      cnt = cnt + CNT_W'(vld[i]);
    end
  end

  assign busy     = |lookHit;
  assign full     = &vld;
  assign retHit   = retire && (|retMatch);
  assign stale    = |oldEnt;
  assign validCnt = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag[i] <= '0;
        ts[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (retire && retMatch[i]) begin
          vld[i] <= 1'b0;
        end else if (insert && freeFound && (freeIdx == IDX_W'(i))) begin
          vld[i] <= 1'b1;
          tag[i] <= lookTag;
          ts[i]  <= nowTs;
        end
      end
    end
  end
endmodule

// File: rtl/lrt_datapath.sv
`timescale 1ns/1ps
module lrt_datapath import lrt_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 7,
  parameter int WR_DEPTH   = 4,
  parameter int RD_DEPTH   = 4,
  parameter int THRESH     = 500,
  parameter int TS_W       = 11,
  parameter int TOT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [ADDR_W-1:0] cplAddr,
  input  tblStrobe_t        strobe,
  output logic [ADDR_W-1:0] lineAddr,
  output logic              lenBad,
  output logic              lineBusy,
  output logic              wrFull,
  output logic              rdFull,
  output logic              retHit,
  output logic              anyStale,
  output logic [TOT_W-1:0]  validTotal
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int SUM_W = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 2;

  logic [TAG_W-1:0] reqTag, cplTag;
  logic [SUM_W-1:0] endByte;
  logic [TS_W-1:0]  nowTs;
  logic             unusedCplOff;

  assign reqTag       = reqAddr[ADDR_W-1:OFF_W];
  assign cplTag       = cplAddr[ADDR_W-1:OFF_W];
  assign unusedCplOff = ^cplAddr[OFF_W-1:0];
  assign lineAddr     = {reqTag, {OFF_W{1'b0}}};
  assign endByte      = SUM_W'(reqAddr[OFF_W-1:0]) + SUM_W'(reqLen);
  assign lenBad       = endByte > SUM_W'(LINE_BYTES);

  // free-running timestamp for entry ages
  always_ff @(posedge clk) begin
    if (!rstN) nowTs <= '0;
    else       nowTs <= nowTs + 1'b1;
  end

  logic [1:0]       busyV, fullV, hitV, staleV;
  logic [TOT_W-1:0] cntV [2];

  // index 0: write-class table, index 1: read-class table
  for (genvar c = 0; c < 2; c++) begin : g_tbl
    localparam int D  = (c == 0) ? WR_DEPTH : RD_DEPTH;
    localparam int CW = $clog2(D+1);
    logic [CW-1:0] cnt;
    logic          ins, ret;
    assign ins = (c == 0) ? strobe.insWr : strobe.insRd;
    assign ret = (c == 0) ? strobe.retWr : strobe.retRd;
    lrt_table #(.DEPTH(D), .TAG_W(TAG_W), .TS_W(TS_W), .THRESH(THRESH)) u_tbl (
      .clk      (clk),
      .rstN     (rstN),
      .lookTag  (reqTag),
      .insert   (ins),
      .retire   (ret),
      .retTag   (cplTag),
      .nowTs    (nowTs),
      .busy     (busyV[c]),
      .full     (fullV[c]),
      .retHit   (hitV[c]),
      .stale    (staleV[c]),
      .validCnt (cnt)
    );
    assign cntV[c] = TOT_W'(cnt);
  end

  assign lineBusy   = |busyV;
  assign wrFull     = fullV[0];
  assign rdFull     = fullV[1];
  assign retHit     = |hitV;
  assign anyStale   = |staleV;
  assign validTotal = cntV[0] + cntV[1];
endmodule

// File: rtl/lrt_control.sv
`timescale 1ns/1ps
module lrt_control import lrt_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int MAX_OUT    = 6,
  parameter int ID_W       = 16,
  parameter int THRESH     = 500,
  parameter int ICACHE_LAT = 2,
  parameter int DCACHE_LAT = 5,
  parameter int LAT_W      = 4,
  parameter int TOT_W      = 4,
  parameter int CNT_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqType,
  input  logic [1:0]        reqMode,
  input  logic              cplValid,
  input  logic              cplWrite,
  input  logic [ADDR_W-1:0] lineAddr,
  input  logic              lenBad,
  input  logic              lineBusy,
  input  logic              wrFull,
  input  logic              rdFull,
  input  logic              retHit,
  input  logic              anyStale,
  input  logic [TOT_W-1:0]  validTotal,
  output tblStrobe_t        strobe,
  output logic              reqAccept,
  output logic [ID_W-1:0]   respId,
  output logic              issueValid,
  output logic [1:0]        issueCmd,
  output logic              issueSuper,
  output logic [ADDR_W-1:0] issueLine,
  output logic [LAT_W-1:0]  issueDelay,
  output logic              deadlock,
  output logic              countMismatch,
  output logic [CNT_W-1:0]  outstanding
);
  localparam int TMR_W = (THRESH > 2) ? $clog2(THRESH) : 1;

  logic              writeKind, kindOk, modeOk, roomOk, accept;
  logic [CNT_W-1:0]  nextOut;
  logic [ID_W-2:0]   idCnt;
  logic              armed, chkNow;
  logic [TMR_W-1:0]  tmr;

  always_comb begin
    writeKind = isWriteKind(reqType);
    kindOk    = reqType != K_BAD;
    modeOk    = reqMode != M_RSVD;
    roomOk    = (outstanding < CNT_W'(MAX_OUT)) && !(writeKind ? wrFull : rdFull);
    accept    = reqValid && kindOk && modeOk && !lenBad && !lineBusy && roomOk;
  end

  assign strobe.insWr = accept && writeKind;
  assign strobe.insRd = accept && !writeKind;
  assign strobe.retWr = cplValid && cplWrite;
  assign strobe.retRd = cplValid && !cplWrite;

  assign reqAccept = accept;
  assign respId    = accept ? {1'b0, idCnt} : {ID_W{1'b1}};
  assign nextOut   = outstanding + CNT_W'(accept) - CNT_W'(retHit);
  assign chkNow    = armed && (tmr == '0);
  assign countMismatch = int'(outstanding) != int'(validTotal);

  // count, IDs and the downstream issue register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= '0;
      idCnt       <= '0;
      issueValid  <= 1'b0;
      issueCmd    <= '0;
      issueSuper  <= 1'b0;
      issueLine   <= '0;
      issueDelay  <= '0;
    end else begin
      outstanding <= nextOut;
      issueValid  <= accept;
      if (accept) begin
        idCnt      <= idCnt + 1'b1;
        issueCmd   <= mapCmd(reqType);
        issueSuper <= reqMode == M_SUPER;
        issueLine  <= lineAddr;
        issueDelay <= (reqType == K_FETCH) ? LAT_W'(ICACHE_LAT) : LAT_W'(DCACHE_LAT);
      end
    end
  end

  // watchdog: periodic check while anything is pending
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      tmr      <= '0;
      deadlock <= 1'b0;
    end else if (chkNow) begin
      if (anyStale) deadlock <= 1'b1;
      if (nextOut != '0) tmr <= TMR_W'(THRESH - 1);
      else               armed <= 1'b0;
    end else if (armed) begin
      tmr <= tmr - 1'b1;
    end else if (accept) begin
      armed <= 1'b1;
      tmr   <= TMR_W'(THRESH - 1);
    end
  end
endmodule

// File: rtl/lineReqTracker.sv
`timescale 1ns/1ps
module lineReqTracker import lrt_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 7,
  parameter int WR_DEPTH   = 4,
  parameter int RD_DEPTH   = 4,
  parameter int MAX_OUT    = 6,
  parameter int ID_W       = 16,
  parameter int THRESH     = 500,
  parameter int ICACHE_LAT = 2,
  parameter int DCACHE_LAT = 5,
  parameter int LAT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [1:0]        reqMode,
  output logic              reqAccept,
  output logic [ID_W-1:0]   respId,
  input  logic              cplValid,
  input  logic              cplWrite,
  input  logic [ADDR_W-1:0] cplAddr,
  output logic              issueValid,
  output logic [1:0]        issueCmd,
  output logic              issueSuper,
  output logic [ADDR_W-1:0] issueLine,
  output logic [LAT_W-1:0]  issueDelay,
  output logic              deadlock,
  output logic              countMismatch
);
  localparam int TS_W  = $clog2(THRESH) + 2;
  localparam int TOT_W = $clog2(WR_DEPTH + RD_DEPTH + 1);
  localparam int CNT_W = $clog2(MAX_OUT + 1);

  tblStrobe_t        strobe;
  logic [ADDR_W-1:0] lineAddr;
  logic              lenBad, lineBusy, wrFull, rdFull, retHit, anyStale;
  logic [TOT_W-1:0]  validTotal;
  logic [CNT_W-1:0]  outstanding;

  lrt_datapath #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W),
    .WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH), .THRESH(THRESH),
    .TS_W(TS_W), .TOT_W(TOT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqLen(reqLen),
    .cplAddr(cplAddr), .strobe(strobe), .lineAddr(lineAddr),
    .lenBad(lenBad), .lineBusy(lineBusy), .wrFull(wrFull), .rdFull(rdFull),
    .retHit(retHit), .anyStale(anyStale), .validTotal(validTotal)
  );

  lrt_control #(
    .ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT), .ID_W(ID_W), .THRESH(THRESH),
    .ICACHE_LAT(ICACHE_LAT), .DCACHE_LAT(DCACHE_LAT), .LAT_W(LAT_W),
    .TOT_W(TOT_W), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqMode(reqMode), .cplValid(cplValid), .cplWrite(cplWrite),
    .lineAddr(lineAddr), .lenBad(lenBad), .lineBusy(lineBusy),
    .wrFull(wrFull), .rdFull(rdFull), .retHit(retHit), .anyStale(anyStale),
    .validTotal(validTotal), .strobe(strobe), .reqAccept(reqAccept),
    .respId(respId), .issueValid(issueValid), .issueCmd(issueCmd),
    .issueSuper(issueSuper), .issueLine(issueLine), .issueDelay(issueDelay),
    .deadlock(deadlock), .countMismatch(countMismatch),
    .outstanding(outstanding)
  );
endmodule

// File: rtl/lrt_checker.sv
`timescale 1ns/1ps
module lrt_checker #(
  parameter int MAX_OUT    = 6,
  parameter int ID_W       = 16,
  parameter int ICACHE_LAT = 2,
  parameter int LAT_W      = 4,
  parameter int CNT_W      = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqAccept,
  input logic [ID_W-1:0]  respId,
  input logic             issueValid,
  input logic [1:0]       issueCmd,
  input logic [LAT_W-1:0] issueDelay,
  input logic             deadlock,
  input logic             countMismatch,
  input logic [CNT_W-1:0] outstanding
);
  logic pastOk;
  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  a_r10_issue_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |=> issueValid);

  a_r10_no_spurious_issue: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(reqAccept)) |-> !issueValid);

  a_r5_id_step: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && reqAccept && $past(reqAccept)) |->
      (respId[ID_W-2:0] == (ID_W-1)'($past(respId[ID_W-2:0]) + 1'b1)));

  a_r9_fetch_latency: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueCmd == 2'd0) |-> (issueDelay == LAT_W'(ICACHE_LAT)));

  a_r11_deadlock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(deadlock)) |-> deadlock);

  a_r13_counts_agree: assert property (@(posedge clk) disable iff (!rstN)
    !countMismatch);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    outstanding <= CNT_W'(MAX_OUT));
endmodule

bind lineReqTracker lrt_checker #(
  .MAX_OUT(MAX_OUT), .ID_W(ID_W), .ICACHE_LAT(ICACHE_LAT),
  .LAT_W(LAT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqAccept(reqAccept), .respId(respId),
  .issueValid(issueValid), .issueCmd(issueCmd), .issueDelay(issueDelay),
  .deadlock(deadlock), .countMismatch(countMismatch), .outstanding(outstanding)
);

// File: tb/lineReqTracker_bench.sv
`timescale 1ns/1ps
module lineReqTracker_bench;
  localparam int THRESH = 200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqType = '0;
  logic [31:0] reqAddr = '0;
  logic [6:0]  reqLen = '0;
  logic [1:0]  reqMode = '0;
  logic        reqAccept;
  logic [15:0] respId;
  logic        cplValid = 1'b0;
  logic        cplWrite = 1'b0;
  logic [31:0] cplAddr = '0;
  logic        issueValid;
  logic [1:0]  issueCmd;
  logic        issueSuper;
  logic [31:0] issueLine;
  logic [3:0]  issueDelay;
  logic        deadlock;
  logic        countMismatch;

  lineReqTracker #(
    .ADDR_W(32), .LINE_BYTES(64), .LEN_W(7), .WR_DEPTH(3), .RD_DEPTH(3),
    .MAX_OUT(4), .ID_W(16), .THRESH(THRESH), .ICACHE_LAT(2), .DCACHE_LAT(5),
    .LAT_W(4)
  ) u_lineReqTracker (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic [1:0]  cmd;
    logic [31:0] line;
    logic        sup;
    logic [3:0]  lat;
  } issItem_t;

  issItem_t expQ[$];
  int nChk = 0;
  int nFail = 0;
  int nextId = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] expCmd(input logic [2:0] k);
    if (k == 3'd1) return 2'd0;
    if (k == 3'd0) return 2'd1;
    if (k == 3'd3 || k == 3'd4) return 2'd3;
    return 2'd2;
  endfunction

  task automatic doReq(input logic [2:0] k, input logic [31:0] a, input logic [6:0] l,
                       input logic [1:0] m, input bit expAcc, input string req);
    logic [15:0] expId;
    issItem_t it;
    @(negedge clk);
    reqValid = 1'b1; reqType = k; reqAddr = a; reqLen = l; reqMode = m;
    #1;
    chk(reqAccept == expAcc, req, "accept", 64'(reqAccept), 64'(expAcc));
    expId = expAcc ? 16'(nextId) : 16'hFFFF;
    chk(respId == expId, "R5", "respId", 64'(respId), 64'(expId));
    if (expAcc) begin
      it.cmd  = expCmd(k);
      it.line = a & ~32'd63;
      it.sup  = (m == 2'd1);
      it.lat  = (k == 3'd1) ? 4'd2 : 4'd5;
      expQ.push_back(it);
      nextId++;
    end
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic doCpl(input bit w, input logic [31:0] a);
    @(negedge clk);
    cplValid = 1'b1; cplWrite = w; cplAddr = a;
    @(posedge clk); #1;
    cplValid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && issueValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R10", "unexpected issue", 64'(issueLine), 64'(0));
      end else begin
        issItem_t e;
        e = expQ.pop_front();
        chk(issueCmd == e.cmd, "R7", "issueCmd", 64'(issueCmd), 64'(e.cmd));
        chk(issueLine == e.line, "R10", "issueLine", 64'(issueLine), 64'(e.line));
        chk(issueSuper == e.sup, "R8", "issueSuper", 64'(issueSuper), 64'(e.sup));
        chk(issueDelay == e.lat, "R9", "issueDelay", 64'(issueDelay), 64'(e.lat));
      end
    end
    if (rstN && countMismatch)
      chk(1'b0, "R13", "countMismatch", 64'(1), 64'(0));
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", "bench timeout", 64'(0), 64'(1));
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk(deadlock == 1'b0, "R11", "deadlock after reset", 64'(deadlock), 64'(0));
    chk(issueValid == 1'b0, "R10", "issueValid after reset", 64'(issueValid), 64'(0));
    chk(countMismatch == 1'b0, "R13", "mismatch after reset", 64'(countMismatch), 64'(0));

    // R1 R7 R8 R9: mix of kinds and modes
    doReq(3'd0, 32'h1004, 7'd4, 2'd0, 1'b1, "R1");
    doReq(3'd1, 32'h2000, 7'd8, 2'd1, 1'b1, "R1");
    doReq(3'd2, 32'h3010, 7'd4, 2'd2, 1'b1, "R1");
    doReq(3'd5, 32'h4000, 7'd8, 2'd0, 1'b1, "R1");
    doReq(3'd3, 32'h5000, 7'd8, 2'd0, 1'b0, "R2");
    doCpl(1'b1, 32'h4000);
    doCpl(1'b0, 32'h3000);                          // wrong class: ignored
    doReq(3'd0, 32'h3020, 7'd4, 2'd0, 1'b0, "R1");
    doReq(3'd0, 32'h4008, 7'd4, 2'd0, 1'b1, "R6");
    doReq(3'd3, 32'h5000, 7'd8, 2'd0, 1'b0, "R2");
    doCpl(1'b0, 32'h4000);
    doReq(3'd3, 32'h5000, 7'd8, 2'd0, 1'b1, "R7");
    doReq(3'd0, 32'hD000, 7'd4, 2'd0, 1'b0, "R2");
    doCpl(1'b1, 32'h3000);
    doCpl(1'b0, 32'h1000);
    doCpl(1'b0, 32'h2000);
    doCpl(1'b1, 32'h5000);

    // R3: one per line across tables
    doReq(3'd2, 32'h6000, 7'd4, 2'd0, 1'b1, "R3");
    doReq(3'd0, 32'h6030, 7'd4, 2'd0, 1'b0, "R3");
    doReq(3'd1, 32'h6000, 7'd4, 2'd1, 1'b0, "R3");
    doReq(3'd0, 32'h6040, 7'd4, 2'd0, 1'b1, "R3");
    doCpl(1'b1, 32'h6000);
    doCpl(1'b0, 32'h6040);

    // R4: illegal requests
    doReq(3'd0, 32'h7030, 7'd17, 2'd0, 1'b0, "R4");
    doReq(3'd7, 32'h7100, 7'd4, 2'd0, 1'b0, "R4");
    doReq(3'd0, 32'h7200, 7'd4, 2'd3, 1'b0, "R4");
    doReq(3'd0, 32'h7030, 7'd16, 2'd0, 1'b1, "R4");
    doReq(3'd4, 32'h8000, 7'd8, 2'd1, 1'b1, "R7");
    doReq(3'd6, 32'h9000, 7'd8, 2'd2, 1'b1, "R7");
    doCpl(1'b0, 32'h7000);
    doCpl(1'b1, 32'h8000);
    doCpl(1'b1, 32'h9000);

    // R12: idle and timely retirement never flag
    repeat (2 * THRESH + 10) @(posedge clk);
    #1 chk(deadlock == 1'b0, "R12", "deadlock idle", 64'(deadlock), 64'(0));
    doReq(3'd0, 32'hA000, 7'd4, 2'd0, 1'b1, "R12");
    repeat (50) @(posedge clk);
    doCpl(1'b0, 32'hA000);
    repeat (3 * THRESH) @(posedge clk);
    #1 chk(deadlock == 1'b0, "R12", "deadlock after timely retire", 64'(deadlock), 64'(0));

    // R11: late arrival caught at the second check, not the first
    doReq(3'd2, 32'hB000, 7'd4, 2'd0, 1'b1, "R11");
    repeat (THRESH - 40) @(posedge clk);
    doReq(3'd0, 32'hC000, 7'd4, 2'd0, 1'b1, "R11");
    doCpl(1'b1, 32'hB000);
    repeat (60) @(posedge clk);
    #1 chk(deadlock == 1'b0, "R11", "deadlock at first check", 64'(deadlock), 64'(0));
    repeat (THRESH - 50) @(posedge clk);
    #1 chk(deadlock == 1'b0, "R11", "deadlock between checks", 64'(deadlock), 64'(0));
    repeat (40) @(posedge clk);
    #1 chk(deadlock == 1'b1, "R11", "deadlock at second check", 64'(deadlock), 64'(1));
    repeat (20) @(posedge clk);
    #1 chk(deadlock == 1'b1, "R11", "deadlock sticky", 64'(deadlock), 64'(1));

    @(negedge clk);
    chk(countMismatch == 1'b0, "R13", "mismatch at end", 64'(countMismatch), 64'(0));
    chk(expQ.size() == 0, "R10", "issues outstanding", 64'(expQ.size()), 64'(0));
    finishRun();
  end
endmodule